// File: doc/BRIEF.md
# Cache Array Debug Access Port

This block lets a debugger read and write the internal arrays of a set-associative instruction cache through two 32-bit registers: a packed command word and a data word. Software loads the command word with a way, an array address, a byte count and a direction, and sets its go bit. The block then runs one fixed-length access on the array side and clears the go bit when it is done. Write data is taken from the low lanes of the data word. Read data is returned in the low lanes, and the lanes outside the requested size are zeroed.

A region of the array address space selects the valid-state arrays instead of the data arrays. If the same valid-state read command is issued again, the block presents the next index each time. When the last index has been read, it wraps to index 0 and moves on to the next way. This way a debugger can dump every valid bit by issuing one command word over and over. Two interleaved array modules are told apart by one address bit. While debug mode is asserted, and while an access is in flight, the block holds off the cache's own fetch and line replacement.

The array side has no back-pressure. The array must accept an enable in any cycle and return read data in the following cycle. The register side is a plain single-cycle write port with a combinational read mux.

Top module: `cache_dbg_port`

## Requirements
- R1: After reset, the command word and the data word both read as zero and no array enable is driven.
- R2: A command write with the go bit (bit 24) set starts an access only while `dbg_mode` is 1. Otherwise the fields are stored, the go bit reads 0 and no array enable follows.
- R3: After an accepted go write, `arr_en` is high for exactly the next cycle. The go bit reads 1 in that cycle and the one after, and reads 0 from the following cycle on.
- R4: While the go bit reads 1, writes to either register are discarded.
- R5: Size field bits 21:20 holding n means n+1 bytes. `arr_be` has bits 0..n set. A read loads the data word with `arr_rdata`, with the bytes above n cleared.
- R6: With direction bit 23 at 1, the access is a write. `arr_we` is high together with `arr_en`, `arr_wdata` carries the data word with the bytes above n cleared, and the data word is left unchanged.
- R7: The command word keeps way in bits 18:16, address in bits 13:0, size in 21:20, direction in 23 and go in 24. All other bits read as 0.
- R8: Address bit 13 drives `arr_mod`: 0 selects the first module (ways 0-7) and 1 selects the second module (ways 8-15).
- R9: Address bit 12 selects the valid-state arrays (`arr_vsel`=1). A fresh valid-state read presents the way field and index address bits 4:0, and `arr_addr` keeps bits 13:5 from the command.
- R10: Repeating the same valid-state read command advances the index by one. After index 31 the index wraps to 0 and the way increments, with way 7 wrapping to 0.
- R11: Any other accepted access ends the walk, so the next valid-state read starts again from its own fields.
- R12: `fetch_block` and `replace_block` are high while `dbg_mode` is 1 or an access is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_mode | input | 1 | Cache is in debug mode |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = command word, 1 = data word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| fetch_block | output | 1 | Hold off cache fetch |
| replace_block | output | 1 | Hold off line replacement |
| arr_en | output | 1 | Array access enable |
| arr_we | output | 1 | Array write enable |
| arr_mod | output | 1 | Array module select |
| arr_vsel | output | 1 | Valid-state array select |
| arr_way | output | 3 | Way presented to the array |
| arr_addr | output | 14 | Array address |
| arr_be | output | 4 | Byte lanes enabled |
| arr_wdata | output | 32 | Array write data |
| arr_rdata | input | 32 | Array read data, one cycle after enable |

## Verification
The capture of read data into the data word and a bus write to the same register can land on the same clock edge, because the go bit is still 1 on that edge. The bench issues a read and then holds the write strobe through the access. It writes the command word in the enable cycle and the data word in the capture cycle. It then expects the captured array value and the original command fields. A second pairing is a walk step that coincides with a change of command key; the bench checks that the new key reloads the walker instead of advancing it.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
  localparam int CTRL_W   = 32;
  localparam int LANES    = 4;
  localparam int DATA_W   = 8 * LANES;
  localparam int AD_LSB   = 0;
  localparam int AD_W     = 14;
  localparam int WAY_LSB  = 16;
  localparam int WAY_W    = 3;
  localparam int SZ_LSB   = 20;
  localparam int SZ_W     = 2;
  localparam int DIR_BIT  = 23;
  localparam int GO_BIT   = 24;
  localparam int MOD_BIT  = 13;
  localparam int VREG_BIT = 12;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_CAPT = 2'd2
  } cdp_phase_e;

  typedef struct packed {
    logic             wr;
    logic [SZ_W-1:0]  size;
    logic [WAY_W-1:0] way;
    logic [AD_W-1:0]  addr;
  } cdp_cmd_t;
endpackage

// File: rtl/cdp_regs.sv
module cdp_regs
  import cdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_mode,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [CTRL_W-1:0] reg_wdata,
  input  logic              done,
  input  logic              cap_en,
  input  logic [CTRL_W-1:0] cap_data,
  output cdp_cmd_t          cmd_q,
  output logic              busy,
  output logic              go,
  output logic [CTRL_W-1:0] data_q,
  output logic [CTRL_W-1:0] reg_rdata
);
  logic              go_q;
  logic              ctrl_hit;
  logic              data_hit;
  logic [CTRL_W-1:0] ctrl_view;
  logic              unused_wbits;

  assign busy     = go_q;
  assign ctrl_hit = reg_wr & ~reg_sel & ~go_q;
  assign data_hit = reg_wr &  reg_sel & ~go_q;
  assign go       = ctrl_hit & reg_wdata[GO_BIT] & dbg_mode;
  assign unused_wbits = ^{reg_wdata[CTRL_W-1:GO_BIT+1], reg_wdata[SZ_LSB+SZ_W],
                          reg_wdata[WAY_LSB+WAY_W], reg_wdata[WAY_LSB-1:AD_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      go_q   <= 1'b0;
      data_q <= '0;
    end else begin
      if (ctrl_hit) begin
        cmd_q <= {reg_wdata[DIR_BIT], reg_wdata[SZ_LSB +: SZ_W],
                  reg_wdata[WAY_LSB +: WAY_W], reg_wdata[AD_LSB +: AD_W]};
        go_q  <= go;
      end else if (done) begin
        go_q  <= 1'b0;
      end
      if (cap_en)        data_q <= cap_data;
      else if (data_hit) data_q <= reg_wdata;
    end
  end

  always_comb begin
    ctrl_view                   = '0;
    ctrl_view[AD_LSB +: AD_W]   = cmd_q.addr;
    ctrl_view[WAY_LSB +: WAY_W] = cmd_q.way;
    ctrl_view[SZ_LSB +: SZ_W]   = cmd_q.size;
    ctrl_view[DIR_BIT]          = cmd_q.wr;
    ctrl_view[GO_BIT]           = go_q;
  end

  assign reg_rdata = reg_sel ? data_q : ctrl_view;
endmodule

// File: rtl/cdp_fsm.sv
module cdp_fsm
  import cdp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic arr_en,
  output logic done
);
  cdp_phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (go) ph_d = PH_ADDR;
      PH_ADDR: ph_d = PH_CAPT;
      PH_CAPT: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign arr_en = (ph_q == PH_ADDR);
  assign done   = (ph_q == PH_CAPT);
endmodule

// File: rtl/cdp_walker.sv
module cdp_walker
  import cdp_pkg::*;
#(
  parameter int WAY_N = 8,
  parameter int IDX_N = 32,
  localparam int IDX_W = $clog2(IDX_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_wr,
  input  logic [WAY_W-1:0] go_way,
  input  logic [AD_W-1:0]  go_addr,
  output logic [WAY_W-1:0] w_way,
  output logic [IDX_W-1:0] w_idx
);
  localparam int KEY_W = WAY_W + AD_W;

  logic             live_q;
  logic [KEY_W-1:0] key_q;
  logic [KEY_W-1:0] key_d;
  logic             vrd;
  logic             same;
  logic [WAY_W-1:0] nxt_way;
  logic [IDX_W-1:0] nxt_idx;

  assign key_d = {go_way, go_addr};
  assign vrd   = ~go_wr & go_addr[VREG_BIT];
  assign same  = live_q & (key_q == key_d);

  always_comb begin
    if (w_idx == IDX_W'(IDX_N - 1)) begin
      nxt_idx = '0;
      nxt_way = (w_way == WAY_W'(WAY_N - 1)) ? '0 : w_way + 1'b1;
    end else begin
      nxt_idx = w_idx + 1'b1;
      nxt_way = w_way;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      key_q  <= '0;
      w_way  <= '0;
      w_idx  <= '0;
    end else if (go) begin
      if (vrd) begin
        live_q <= 1'b1;
        key_q  <= key_d;
        if (same) begin
          w_way <= nxt_way;
          w_idx <= nxt_idx;
        end else begin
          w_way <= go_way;
          w_idx <= go_addr[IDX_W-1:0];
        end
      end else begin
        live_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cdp_lanes.sv
module cdp_lanes
  import cdp_pkg::*;
(
  input  logic [SZ_W-1:0]   size,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] mask
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be[i]          = ((SZ_W+1)'(i) <= {1'b0, size});
    assign mask[8*i +: 8] = {8{be[i]}};
  end
endmodule

// File: rtl/cache_dbg_port.sv
module cache_dbg_port
  import cdp_pkg::*;
#(
  parameter int WAY_N = 8,
  parameter int IDX_N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_mode,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  output logic              fetch_block,
  output logic              replace_block,
  output logic              arr_en,
  output logic              arr_we,
  output logic              arr_mod,
  output logic              arr_vsel,
  output logic [WAY_W-1:0]  arr_way,
  output logic [AD_W-1:0]   arr_addr,
  output logic [LANES-1:0]  arr_be,
  output logic [DATA_W-1:0] arr_wdata,
  input  logic [DATA_W-1:0] arr_rdata
);
  localparam int IDX_W = $clog2(IDX_N);

  cdp_cmd_t          cmd_q;
  logic              busy;
  logic              go;
  logic              done;
  logic              cap_en;
  logic              walk;
  logic [CTRL_W-1:0] data_q;
  logic [DATA_W-1:0] mask;
  logic [WAY_W-1:0]  w_way;
  logic [IDX_W-1:0]  w_idx;

  cdp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .done(done), .cap_en(cap_en), .cap_data(arr_rdata & mask),
    .cmd_q(cmd_q), .busy(busy), .go(go), .data_q(data_q), .reg_rdata(reg_rdata)
  );

  cdp_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go), .arr_en(arr_en), .done(done)
  );

  cdp_walker #(.WAY_N(WAY_N), .IDX_N(IDX_N)) u_walk (
    .clk(clk), .rst_n(rst_n), .go(go),
    .go_wr(reg_wdata[DIR_BIT]),
    .go_way(reg_wdata[WAY_LSB +: WAY_W]),
    .go_addr(reg_wdata[AD_LSB +: AD_W]),
    .w_way(w_way), .w_idx(w_idx)
  );

  cdp_lanes u_lanes (
    .size(cmd_q.size), .be(arr_be), .mask(mask)
  );

  assign cap_en    = done & ~cmd_q.wr;
  assign arr_vsel  = cmd_q.addr[VREG_BIT];
  assign arr_mod   = cmd_q.addr[MOD_BIT];
  assign walk      = arr_vsel & ~cmd_q.wr;
  assign arr_way   = walk ? w_way : cmd_q.way;
  assign arr_addr  = walk ? {cmd_q.addr[AD_W-1:IDX_W], w_idx} : cmd_q.addr;
  assign arr_we    = arr_en & cmd_q.wr;
  assign arr_wdata = data_q & mask;

  assign fetch_block   = dbg_mode | busy;
  assign replace_block = dbg_mode | busy;
endmodule

// File: rtl/cdp_chk.sv
module cdp_chk
  import cdp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             arr_en,
  input logic [LANES-1:0] arr_be,
  input logic [19:0]      cfg
);
  a_r3_en_single: assert property (@(posedge clk) disable iff (!rst_n)
    arr_en |=> !arr_en);
  a_r3_en_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_en |-> busy);
  a_r3_go_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arr_en |=> busy ##1 !busy);
  a_r4_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg));
  a_r5_be_contig: assert property (@(posedge clk) disable iff (!rst_n)
    arr_en |-> (arr_be[0] && ((arr_be & (arr_be + 1'b1)) == '0)));
endmodule

bind cache_dbg_port cdp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .arr_en(arr_en),
  .arr_be(arr_be), .cfg(cmd_q)
);

// File: tb/tb_cache_dbg_port.sv
`timescale 1ns/1ps
module tb_cache_dbg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_mode = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fetch_block, replace_block;
  logic        arr_en, arr_we, arr_mod, arr_vsel;
  logic [2:0]  arr_way;
  logic [13:0] arr_addr;
  logic [3:0]  arr_be;
  logic [31:0] arr_wdata;
  logic [31:0] arr_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [31:0] GO = 32'h0100_0000;

  // {command, array data, expected data word, expected lanes, expected module}
  localparam logic [100:0] VEC [4] = '{
    {32'h0032_0123, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'hF, 1'b0},
    {32'h0005_2045, 32'hCAFE_F00D, 32'h0000_000D, 4'h1, 1'b1},
    {32'h0017_0FFF, 32'h1234_5678, 32'h0000_5678, 4'h3, 1'b0},
    {32'h0020_2ABC, 32'hA5A5_A5A5, 32'h00A5_A5A5, 4'h7, 1'b1}
  };

  cache_dbg_port dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic rreg(input logic sel, output logic [31:0] v);
    reg_sel = sel;
    #0.5;
    v = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic fin();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic vacc(input logic [31:0] c, input logic [2:0] ew, input logic [13:0] ea,
                      input logic em, input string t);
    wreg(1'b0, c);
    chk({t, " vsel"}, 32'(arr_vsel), 32'd1);
    chk({t, " way"}, 32'(arr_way), 32'(ew));
    chk({t, " addr"}, 32'(arr_addr), 32'(ea));
    chk({t, " mod"}, 32'(arr_mod), 32'(em));
    fin();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rreg(1'b0, v); chk("R1 command after reset", v, 32'h0);
    rreg(1'b1, v); chk("R1 data after reset", v, 32'h0);
    chk("R1 no enable after reset", 32'(arr_en), 32'd0);
    chk("R12 fetch idle", 32'(fetch_block), 32'd0);

    // R2 / R7: go outside debug mode, all bits written
    wreg(1'b0, 32'hFFFF_FFFF);
    chk("R2 no enable outside debug", 32'(arr_en), 32'd0);
    rreg(1'b0, v); chk("R7 field readback, R2 go stays 0", v, 32'h00B7_3FFF);
    dbg_mode = 1'b1; #0.5;
    chk("R12 fetch blocked", 32'(fetch_block), 32'd1);
    chk("R12 replace blocked", 32'(replace_block), 32'd1);

    // table of read vectors: R3, R5, R7, R8
    for (int i = 0; i < 4; i++) begin
      logic [31:0] c;
      c = VEC[i][100:69];
      arr_rdata = VEC[i][68:37];
      wreg(1'b0, c | GO);
      chk("R3 enable cycle", 32'(arr_en), 32'd1);
      chk("R5 lanes", 32'(arr_be), 32'(VEC[i][4:1]));
      chk("R7 way", 32'(arr_way), 32'(c[18:16]));
      chk("R7 address", 32'(arr_addr), 32'(c[13:0]));
      chk("R8 module", 32'(arr_mod), 32'(VEC[i][0]));
      chk("R7 read direction", 32'(arr_we), 32'd0);
      rreg(1'b0, v); chk("R3 go set in enable cycle", 32'(v[24]), 32'd1);
      @(negedge clk);
      chk("R3 enable one cycle", 32'(arr_en), 32'd0);
      rreg(1'b0, v); chk("R3 go set in capture cycle", 32'(v[24]), 32'd1);
      @(negedge clk);
      rreg(1'b0, v); chk("R3 go cleared", v, c);
      rreg(1'b1, v); chk("R5 justified read data", v, VEC[i][36:5]);
    end

    // R6: write access
    wreg(1'b1, 32'h1122_3344);
    wreg(1'b0, 32'h0193_0040);
    chk("R6 write enable", 32'(arr_we), 32'd1);
    chk("R6 write data lanes", arr_wdata, 32'h0000_3344);
    chk("R6 lanes", 32'(arr_be), 32'h3);
    chk("R6 way", 32'(arr_way), 32'd3);
    fin();
    rreg(1'b1, v); chk("R6 data word kept", v, 32'h1122_3344);

    // R4: writes during busy, data write on the capture edge
    arr_rdata = 32'h55AA_55AA;
    wreg(1'b0, 32'h0130_0040);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h00B7_0FFF;
    @(negedge clk);
    reg_sel = 1'b1; reg_wdata = 32'h9999_9999;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0;
    rreg(1'b1, v); chk("R4 data write ignored, capture kept", v, 32'h55AA_55AA);
    rreg(1'b0, v); chk("R4 command write ignored", v, 32'h0030_0040);

    // R9 / R10 / R11: valid-state walk
    vacc(32'h0136_101E, 3'd6, 14'h101E, 1'b0, "R9 fresh walk");
    vacc(32'h0136_101E, 3'd6, 14'h101F, 1'b0, "R10 step");
    vacc(32'h0136_101E, 3'd7, 14'h1000, 1'b0, "R10 index wrap");
    vacc(32'h0136_101E, 3'd7, 14'h1001, 1'b0, "R10 step after wrap");
    vacc(32'h0137_101F, 3'd7, 14'h101F, 1'b0, "R11 new key reloads");
    vacc(32'h0137_101F, 3'd0, 14'h1000, 1'b0, "R10 way wrap");
    wreg(1'b0, VEC[0][100:69] | GO); fin();
    vacc(32'h0137_101F, 3'd7, 14'h101F, 1'b0, "R11 restart after plain read");
    vacc(32'h0136_301E, 3'd6, 14'h301E, 1'b1, "R8 second module valid");

    dbg_mode = 1'b0; #0.5;
    chk("R12 fetch released", 32'(fetch_block), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule